// File: doc/BRIEF.md
# Two-Wire Programming Word Reader

This block is the host side of a two-wire programming link. It owns a clock line and a bidirectional data line. It fetches one 16-bit word from a target that is already in programming mode, such as a status, identifier or checksum word. The word arrives as two byte reads. Both reads are woven into a single command stream, and that stream is taken from a small pattern memory the host fills beforehand.

A `start` pulse launches one fetch. The block first sends a short run of command bits and then frees the data line for two clocks. It receives the high byte and lets one quiet clock pass. It then sends a longer run of command bits from a later spot in the same pattern, frees the line again, receives the low byte and lets another quiet clock pass. It closes with a single command bit. The assembled word is presented together with a one-cycle `done` pulse. The serial clock is a divided copy of the system clock and rests low between fetches.

Top module: `prog_word_reader`

## Requirements
- R1: After reset, `sclOut` is low, `sdaOe` is low, `done` is low and `result` is zero.
- R2: The first 11 serial clock pulses carry pattern bits 0 to 10 with `sdaOe` high. Pattern bit i is bit (7 - i mod 8) of pattern byte i/8, so each byte is sent MSB first.
- R3: After each command segment that precedes a reception, exactly two clock pulses run with `sdaOe` low before the first data bit.
- R4: Each byte is received over eight clock pulses with `sdaOe` low. `sdaIn` is sampled at the rising edge of `sclOut`, and the first sample is the byte's MSB.
- R5: After each received byte, exactly one clock pulse runs with `sdaOe` low before the next command bits.
- R6: The second command segment has 12 pulses carrying pattern bits 16 to 27 with `sdaOe` high.
- R7: The fetch ends with one pulse carrying pattern bit 32 with `sdaOe` high, for a total of exactly 46 clock pulses.
- R8: `done` is a single-cycle pulse after the last pulse. `result` then equals (first byte << 8) | second byte, and `result` changes only in a cycle where `done` is high.
- R9: Each serial clock pulse stays high for DIV_HALF system clocks. `sdaOut` and `sdaOe` change only while `sclOut` is low. Between fetches `sclOut` and `sdaOe` are low.
- R10: A `start` pulse that arrives while a fetch is running is ignored, so the running fetch still makes exactly 46 pulses and no new fetch follows it.
- R11: The level of `sdaIn` outside the 16 reception pulses has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one word fetch |
| vecWrEn | input | 1 | Write enable for the command pattern memory |
| vecWrAddr | input | 3 | Pattern byte address |
| vecWrData | input | 8 | Pattern byte value |
| sdaIn | input | 1 | Data line level as seen from the pin |
| sdaOut | output | 1 | Value driven onto the data line |
| sdaOe | output | 1 | Data line output enable (low means released) |
| sclOut | output | 1 | Serial clock to the target |
| result | output | 16 | Fetched word |
| done | output | 1 | One-cycle pulse when `result` is valid |

## Verification
The hardest case to reach is a fault in only one segment of the stream, such as one turnaround pulse too many before the low byte. In that case the word can still look plausible while later pulses slip by one. To catch it, the bench logs `sdaOe` and `sdaOut` at every rising edge of `sclOut` and checks each pulse index against the pattern layout computed for it. A model target answers from a pulse counter and drives noise outside the reception windows. Random patterns and bytes, together with all-zero, all-one and alternating corner values, make a slipped pulse show up as wrong data. A second `start` is injected in the middle of some fetches.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  // Pointer into the command pattern; 6 bits cover patterns up to 64 bits.
  localparam int PTR_W = 6;

  typedef enum logic [3:0] {
    PH_IDLE, PH_MCMD, PH_MTURN, PH_MRX, PH_MGAP,
    PH_LCMD, PH_LTURN, PH_LRX, PH_LGAP, PH_TAIL
  } phase_t;

  typedef struct packed {
    logic             shiftIn;  // sample data line into receive register
    logic             finish;   // latch the assembled word
    logic             drive;    // own the data line
    logic [PTR_W-1:0] ptr;      // pattern bit to present
  } pwr_strobe_t;
endpackage

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int MSB_LEN  = 11,
  parameter int LSB_OFF  = 16,
  parameter int LSB_LEN  = 12,
  parameter int TAIL_OFF = 32,
  parameter int TURN_LEN = 2,
  parameter int GAP_LEN  = 1,
  parameter int RX_LEN   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output pwr_strobe_t strb,
  output logic        sclOut,
  output logic        done
);
  localparam int DIV_W  = (2 * DIV_HALF > 2) ? $clog2(2 * DIV_HALF) : 1;
  localparam int MAXLEN = (MSB_LEN > LSB_LEN) ? MSB_LEN : LSB_LEN;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_t           phase, phaseNext;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             midHalf, lastHalf, phaseEnd;
  logic [CNT_W-1:0] lenM1;
  logic [PTR_W-1:0] base;

  assign midHalf  = (divCnt == DIV_W'(DIV_HALF - 1));
  assign lastHalf = (divCnt == DIV_W'(2 * DIV_HALF - 1));

  always_comb begin
    lenM1     = '0;
    base      = '0;
    phaseNext = PH_IDLE;
    unique case (phase)
      PH_MCMD:  begin lenM1 = CNT_W'(MSB_LEN - 1);  base = '0;              phaseNext = PH_MTURN; end
      PH_MTURN: begin lenM1 = CNT_W'(TURN_LEN - 1);                         phaseNext = PH_MRX;   end
      PH_MRX:   begin lenM1 = CNT_W'(RX_LEN - 1);                           phaseNext = PH_MGAP;  end
      PH_MGAP:  begin lenM1 = CNT_W'(GAP_LEN - 1);                          phaseNext = PH_LCMD;  end
      PH_LCMD:  begin lenM1 = CNT_W'(LSB_LEN - 1);  base = PTR_W'(LSB_OFF);  phaseNext = PH_LTURN; end
      PH_LTURN: begin lenM1 = CNT_W'(TURN_LEN - 1);                         phaseNext = PH_LRX;   end
      PH_LRX:   begin lenM1 = CNT_W'(RX_LEN - 1);                           phaseNext = PH_LGAP;  end
      PH_LGAP:  begin lenM1 = CNT_W'(GAP_LEN - 1);                          phaseNext = PH_TAIL;  end
      PH_TAIL:  begin lenM1 = '0;                   base = PTR_W'(TAIL_OFF); phaseNext = PH_IDLE;  end
      default:  begin lenM1 = '0;                                           phaseNext = PH_IDLE;  end
    endcase
  end

  assign phaseEnd = lastHalf && (bitCnt == lenM1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      sclOut <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == PH_IDLE) begin
        divCnt <= '0;
        bitCnt <= '0;
        sclOut <= 1'b0;
        if (start) phase <= PH_MCMD;
      end else begin
        if (midHalf)  sclOut <= 1'b1;
        if (lastHalf) sclOut <= 1'b0;
        divCnt <= lastHalf ? '0 : divCnt + 1'b1;
        if (lastHalf) begin
          if (phaseEnd) begin
            bitCnt <= '0;
            phase  <= phaseNext;
            if (phase == PH_TAIL) done <= 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    strb.shiftIn = ((phase == PH_MRX) || (phase == PH_LRX)) && midHalf;
    strb.finish  = (phase == PH_TAIL) && phaseEnd;
    strb.drive   = (phase == PH_MCMD) || (phase == PH_LCMD) || (phase == PH_TAIL);
    strb.ptr     = base + PTR_W'(bitCnt);
  end
endmodule

// File: rtl/pwr_dp.sv
module pwr_dp
  import pwr_pkg::*;
#(
  parameter int VEC_BYTES = 5,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              vecWrEn,
  input  logic [ADDR_W-1:0] vecWrAddr,
  input  logic [7:0]        vecWrData,
  input  pwr_strobe_t       strb,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic [15:0]       result
);
  localparam int PAT_BITS = 8 * VEC_BYTES;

  logic [PAT_BITS-1:0] patFlat;
  logic [15:0]         rxShift;
  logic                cmdBit;

  for (genvar g = 0; g < VEC_BYTES; g++) begin : g_vec
    logic [7:0] vecByte;
    always_ff @(posedge clk) begin
      if (!rstN)                                        vecByte <= '0;
      else if (vecWrEn && (vecWrAddr == ADDR_W'(g)))     vecByte <= vecWrData;
    end
    assign patFlat[PAT_BITS-1-8*g -: 8] = vecByte;
  end

  always_comb begin
    cmdBit = 1'b0;
    if (int'(strb.ptr) < PAT_BITS) cmdBit = patFlat[PAT_BITS-1-int'(strb.ptr)];
  end

  assign sdaOe  = strb.drive;
  assign sdaOut = strb.drive & cmdBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      result  <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= {rxShift[14:0], sdaIn};
      if (strb.finish)  result  <= rxShift;
    end
  end
endmodule

// File: rtl/prog_word_reader.sv
module prog_word_reader #(
  parameter int DIV_HALF  = 2,
  parameter int VEC_BYTES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        vecWrEn,
  input  logic [2:0]  vecWrAddr,
  input  logic [7:0]  vecWrData,
  input  logic        sdaIn,
  output logic        sdaOut,
  output logic        sdaOe,
  output logic        sclOut,
  output logic [15:0] result,
  output logic        done
);
  localparam int ADDR_W = 3;

  pwr_pkg::pwr_strobe_t strb;

  pwr_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strb(strb), .sclOut(sclOut), .done(done)
  );

  pwr_dp #(.VEC_BYTES(VEC_BYTES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .vecWrEn(vecWrEn), .vecWrAddr(vecWrAddr), .vecWrData(vecWrData),
    .strb(strb), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .result(result)
  );
endmodule

// File: rtl/pwr_checker.sv
module pwr_checker #(
  parameter int DIV_HALF = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        sdaOut,
  input logic        sdaOe,
  input logic        sclOut,
  input logic [15:0] result,
  input logic        done
);
  int hiCnt;
  always_ff @(posedge clk) begin
    if (!rstN || !sclOut) hiCnt <= 0;
    else                  hiCnt <= hiCnt + 1;
  end

  assert_high_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> (hiCnt == DIV_HALF));

  assert_oe_change_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclOut);

  assert_data_change_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOe && !$stable(sdaOut)) |-> !sclOut);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_result_on_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> done);

  assert_idle_lines_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!sclOut && !sdaOe));
endmodule

bind prog_word_reader pwr_checker #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOut(sdaOut), .sdaOe(sdaOe),
  .sclOut(sclOut), .result(result), .done(done)
);

// File: tb/sim_prog_word_reader.sv
`timescale 1ns/1ps
module sim_prog_word_reader;
  localparam int DIVH = 2;
  localparam int TOTAL = 46;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic vecWrEn = 1'b0;
  logic [2:0] vecWrAddr = '0;
  logic [7:0] vecWrData = '0;
  logic sdaIn;
  logic sdaOut, sdaOe, sclOut, done;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  logic [7:0] hiByte = '0, loByte = '0;
  logic seenOe [64];
  logic seenDat [64];

  always #10 clk = ~clk;

  prog_word_reader #(.DIV_HALF(DIVH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .vecWrEn(vecWrEn),
    .vecWrAddr(vecWrAddr), .vecWrData(vecWrData), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .sclOut(sclOut),
    .result(result), .done(done)
  );

  // Model target: answers by pulse index, noise outside reception windows.
  function automatic logic tgtBit(int n, logic [7:0] hb, logic [7:0] lb);
    if (n >= 13 && n <= 20) return hb[7-(n-13)];
    if (n >= 36 && n <= 43) return lb[7-(n-36)];
    return n[0];
  endfunction
  assign sdaIn = tgtBit(edgeCnt, hiByte, loByte);

  always @(posedge sclOut) begin
    if (edgeCnt < 64) begin
      seenOe[edgeCnt]  = sdaOe;
      seenDat[edgeCnt] = sdaOut;
    end
    edgeCnt = edgeCnt + 1;
  end

  function automatic logic expOe(int n);
    return (n <= 10) || (n >= 22 && n <= 33) || (n == 45);
  endfunction

  function automatic logic expDat(int n, logic [39:0] pat);
    if (n <= 10)            return pat[39-n];
    if (n >= 22 && n <= 33) return pat[39-(16+n-22)];
    if (n == 45)            return pat[39-32];
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadPattern(input logic [39:0] pat);
    for (int b = 0; b < 5; b++) begin
      @(negedge clk);
      vecWrEn = 1'b1; vecWrAddr = 3'(b); vecWrData = pat[39-8*b -: 8];
    end
    @(negedge clk);
    vecWrEn = 1'b0;
  endtask

  // Count mismatching pulses in an index range for driven or released slots.
  function automatic int badRange(int lo, int hi, logic [39:0] pat, bit chkDat);
    int bad = 0;
    for (int n = lo; n <= hi; n++) begin
      if (seenOe[n] !== expOe(n)) bad++;
      else if (chkDat && expOe(n) && (seenDat[n] !== expDat(n, pat))) bad++;
    end
    return bad;
  endfunction

  task automatic runFetch(input logic [39:0] pat, input logic [7:0] hb,
                          input logic [7:0] lb, input bit restartMid);
    int waitCyc;
    int cntAtDone;
    bit got;
    logic [15:0] expWord;
    loadPattern(pat);
    hiByte = hb; loByte = lb;
    expWord = {hb, lb};
    @(negedge clk);
    edgeCnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0;
    waitCyc = 0;
    while (!got && waitCyc < 2000) begin
      @(negedge clk);
      waitCyc++;
      if (restartMid && waitCyc == 60) start = 1'b1;
      else start = 1'b0;
      if (done) got = 1;
    end
    start = 1'b0;
    check(got, "R8", "done seen", int'(got), 1);
    if (!got) return;
    check(result == expWord, "R8/R11", "result word", int'(result), int'(expWord));
    cntAtDone = edgeCnt;
    check(cntAtDone == TOTAL, "R7", "pulse count", cntAtDone, TOTAL);
    check(badRange(0, 10, pat, 1) == 0, "R2", "first command segment bad pulses",
          badRange(0, 10, pat, 1), 0);
    check((badRange(11, 12, pat, 0) + badRange(34, 35, pat, 0)) == 0, "R3",
          "turnaround bad pulses", badRange(11, 12, pat, 0) + badRange(34, 35, pat, 0), 0);
    check((badRange(13, 20, pat, 0) + badRange(36, 43, pat, 0)) == 0, "R4",
          "reception oe bad pulses", badRange(13, 20, pat, 0) + badRange(36, 43, pat, 0), 0);
    check((badRange(21, 21, pat, 0) + badRange(44, 44, pat, 0)) == 0, "R5",
          "gap bad pulses", badRange(21, 21, pat, 0) + badRange(44, 44, pat, 0), 0);
    check(badRange(22, 33, pat, 1) == 0, "R6", "second command segment bad pulses",
          badRange(22, 33, pat, 1), 0);
    check(badRange(45, 45, pat, 1) == 0, "R7", "tail bit", badRange(45, 45, pat, 1), 0);
    @(negedge clk);
    check(!done, "R8", "done width", int'(done), 0);
    repeat (3 * DIVH * 4) @(negedge clk);
    check(!sclOut && !sdaOe, "R9", "idle lines", {sclOut, sdaOe}, 0);
    if (restartMid)
      check(edgeCnt == TOTAL, "R10", "pulses after mid start", edgeCnt, TOTAL);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(!sclOut && !sdaOe && !done && result == 16'h0, "R1", "reset state",
          {sclOut, sdaOe, done, |result}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!sclOut && !sdaOe && !done && result == 16'h0, "R1", "after reset release",
          {sclOut, sdaOe, done, |result}, 0);

    runFetch(40'h0, 8'h00, 8'hFF, 0);
    runFetch({40{1'b1}}, 8'hFF, 8'h00, 0);
    runFetch(40'hA5_5A_C3_3C_96, 8'hA5, 8'h5A, 1);
    runFetch(40'h80_01_80_01_80, 8'h01, 8'h80, 0);
    for (int t = 0; t < 16; t++) begin
      logic [39:0] p;
      p = {8'($urandom), $urandom};
      runFetch(p, 8'($urandom), 8'($urandom), ($urandom % 3) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule